// File: doc/BRIEF.md
# LCD Timing Generator with Frame-Boundary Shadow Registers

This block drives the raster timing of a parallel RGB panel. From a set of programmed porch, sync-width and active-size values it produces horizontal sync, vertical sync, a data-enable strobe, and the x/y coordinate of the current visible pixel. A pixel-rate strobe comes from a programmable divider of the block clock, or the divider can be bypassed so that the pixel rate equals the clock rate.

Software loads settings through a simple write port into working registers. The settings the raster actually uses are shadow copies of those registers. The shadows reload only at the frame boundary, so a frame is never drawn with half-updated settings, and the display can only start or stop there. While the display is stopped, the shadows follow the working registers on every clock. A frame interrupt goes up at each vertical sync leading edge. It has a sticky pending bit that software clears by writing a one.

Top module: `lcd_tgen`

## Requirements
- R1: After reset all outputs are low: hsync_o, vsync_o, de_o, pix_tick_o, irq_o and irq_pend_o are 0, and x_o and y_o are 0.
- R2: Each timing field holds its count minus one. A line lasts (hsync + hback + width + hfront) pixel periods and is ordered sync, back porch, active, front porch. A frame lasts (vsync + vback + height + vfront) lines, in the same order.
- R3: With the divide-select bit set, pix_tick_o pulses once every (div field + 1) clocks, for divisors 1 to 256. With the bit clear, it pulses on every clock.
- R4: hsync_o is high during the sync pixels of each line and vsync_o is high during the sync lines of each frame. Each sync output is then XORed with its own inversion bit.
- R5: Settings written while the display runs take effect only at the frame boundary. This covers all timing fields, the divider, the display enable and the inversion bits. The new settings apply from the pixel period after the last pixel of the last line. While the display is stopped, a write takes effect on the following clock.
- R6: de_o is high only while both the horizontal and the vertical position are in their active regions. x_o and y_o count from 0 at the first active pixel and line, and are 0 whenever de_o is low.
- R7: While the display is stopped, the counters stay at the frame origin, de_o and pix_tick_o are 0, and each sync output sits at its inactive level, which equals its inversion bit.
- R8: irq_pend_o is set on each vsync leading edge and stays set until a write of 1 to bit 0 of the status register. If the set and the clear fall in the same cycle, the set wins. irq_o = irq_pend_o AND the interrupt enable. The interrupt enable acts at once and is not shadowed.
- R9: Register map (3-bit address, 32-bit data).
  - Address 0, control:
    - bit0: display enable
    - bit1: divide select
    - bit2: hsync inversion
    - bit3: vsync inversion
    - bit4: interrupt enable
    - bits[15:8]: divisor minus one
  - Address 1, horizontal porches and address 2, vertical porches, each with the same layout:
    - bits[7:0]: sync width minus one
    - bits[15:8]: back porch minus one
    - bits[23:16]: front porch minus one
  - Address 3, size:
    - bits[15:0]: width minus one
    - bits[31:16]: height minus one
  - Address 4, status: bit0 is write-one-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| pix_tick_o | output | 1 | Pixel-rate strobe |
| hsync_o | output | 1 | Horizontal sync, polarity programmable |
| vsync_o | output | 1 | Vertical sync, polarity programmable |
| de_o | output | 1 | Data enable, visible pixel |
| x_o | output | SW | Visible column |
| y_o | output | SW | Visible row |
| irq_o | output | 1 | Frame interrupt |
| irq_pend_o | output | 1 | Sticky frame interrupt status |

## Verification
The hardest condition to reach from the ports is a settings write that lands in the middle of a running frame, including a write that stops the display. The stimulus waits for a data-enable rising edge, issues the write there, and then checks that the following line still uses the old sync width and keeps producing active pixels. After the next vsync edge it checks the new width. The same-cycle collision of a status clear with a vsync leading edge is forced by driving the clear on the very sample at which the vsync edge is seen. A behavioural raster model built from absolute positions runs beside the design and is compared on every clock.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;
  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_HTIM = 3'd1,
    REG_VTIM = 3'd2,
    REG_SIZE = 3'd3,
    REG_STAT = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  localparam int CTRL_EN      = 0;
  localparam int CTRL_DSEL    = 1;
  localparam int CTRL_HINV    = 2;
  localparam int CTRL_VINV    = 3;
  localparam int CTRL_IRQ     = 4;
  localparam int CTRL_DIV_LSB = 8;
  localparam int SYNC_LSB     = 0;
  localparam int BACK_LSB     = 8;
  localparam int FRONT_LSB    = 16;
  localparam int WID_LSB      = 0;
  localparam int HGT_LSB      = 16;
  localparam int NUM_AXES     = 2;
endpackage

// File: rtl/lcd_tgen_regs.sv
module lcd_tgen_regs
  import lcd_tgen_pkg::*;
#(
  parameter int PW = 8,
  parameter int SW = 11,
  parameter int DW = 8
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 wr_en_i,
  input  logic [2:0]                           wr_addr_i,
  input  logic [31:0]                          wr_data_i,
  input  logic                                 load_i,
  input  logic                                 vs_rise_i,
  output logic                                 a_en_o,
  output logic                                 a_dsel_o,
  output logic [NUM_AXES-1:0]                  a_inv_o,
  output logic [DW-1:0]                        a_div_o,
  output logic [NUM_AXES-1:0][2:0][PW-1:0]     a_por_o,
  output logic [NUM_AXES-1:0][SW-1:0]          a_act_o,
  output logic                                 irq_en_o,
  output logic                                 pend_o
);
  logic                        w_en, w_dsel;
  logic [NUM_AXES-1:0]         w_inv;
  logic [DW-1:0]               w_div;
  logic [NUM_AXES-1:0][SW-1:0] w_act;
  logic                        wr_ctrl, wr_size, wr_stat;

  assign wr_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);
  assign wr_size = wr_en_i && (wr_addr_i == REG_SIZE);
  assign wr_stat = wr_en_i && (wr_addr_i == REG_STAT) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_en     <= 1'b0;
      w_dsel   <= 1'b0;
      w_inv    <= '0;
      w_div    <= '0;
      irq_en_o <= 1'b0;
    end else if (wr_ctrl) begin
      w_en     <= wr_data_i[CTRL_EN];
      w_dsel   <= wr_data_i[CTRL_DSEL];
      w_inv    <= {wr_data_i[CTRL_VINV], wr_data_i[CTRL_HINV]};
      w_div    <= wr_data_i[CTRL_DIV_LSB +: DW];
      irq_en_o <= wr_data_i[CTRL_IRQ];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_act <= '0;
    end else if (wr_size) begin
      w_act[0] <= wr_data_i[WID_LSB +: SW];
      w_act[1] <= wr_data_i[HGT_LSB +: SW];
    end
  end

  // shadows of control and size
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_en_o   <= 1'b0;
      a_dsel_o <= 1'b0;
      a_inv_o  <= '0;
      a_div_o  <= '0;
      a_act_o  <= '0;
    end else if (load_i) begin
      a_en_o   <= w_en;
      a_dsel_o <= w_dsel;
      a_inv_o  <= w_inv;
      a_div_o  <= w_div;
      a_act_o  <= w_act;
    end
  end

  // per-axis porch registers, one address each
  for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_por
    logic [2:0][PW-1:0] w_q, s_q;
    logic               hit;
    assign hit = wr_en_i && (wr_addr_i == 3'(REG_HTIM + ax));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        w_q <= '0;
      end else if (hit) begin
        w_q[0] <= wr_data_i[SYNC_LSB  +: PW];
        w_q[1] <= wr_data_i[BACK_LSB  +: PW];
        w_q[2] <= wr_data_i[FRONT_LSB +: PW];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     s_q <= '0;
      else if (load_i) s_q <= w_q;
    end

    assign a_por_o[ax] = s_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_o <= 1'b0;
    else if (vs_rise_i) pend_o <= 1'b1;
    else if (wr_stat)   pend_o <= 1'b0;
  end
endmodule

// File: rtl/lcd_tgen_pixdiv.sv
module lcd_tgen_pixdiv #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          dsel_i,
  input  logic [DW-1:0] div_m1_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = !dsel_i || (cnt_q == div_m1_i);
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i || wrap) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_tgen_axis.sv
module lcd_tgen_axis
  import lcd_tgen_pkg::*;
#(
  parameter int PW = 8,
  parameter int SW = 11,
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [PW-1:0] sync_m1_i,
  input  logic [PW-1:0] back_m1_i,
  input  logic [SW-1:0] act_m1_i,
  input  logic [PW-1:0] front_m1_i,
  output seg_e          seg_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  seg_e          seg_q;
  logic [CW-1:0] cnt_q, len;
  logic          seg_end;

  always_comb begin
    unique case (seg_q)
      SEG_SYNC:  len = CW'(sync_m1_i);
      SEG_BACK:  len = CW'(back_m1_i);
      SEG_ACT:   len = CW'(act_m1_i);
      default:   len = CW'(front_m1_i);
    endcase
  end

  assign seg_end = (cnt_q == len);
  assign last_o  = (seg_q == SEG_FRONT) && seg_end;
  assign seg_o   = seg_q;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
    end else if (clr_i) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
    end else if (step_i) begin
      if (seg_end) begin
        seg_q <= seg_e'(seg_q + 2'd1);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
  import lcd_tgen_pkg::*;
#(
  parameter int PW = 8,
  parameter int SW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [31:0]   wr_data_i,
  output logic          pix_tick_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [SW-1:0] x_o,
  output logic [SW-1:0] y_o,
  output logic          irq_o,
  output logic          irq_pend_o
);
  localparam int CW = (SW > PW) ? SW : PW;

  logic                              a_en, a_dsel, irq_en, tick;
  logic [NUM_AXES-1:0]               a_inv, last, step, in_act, sync_raw, sync_out;
  logic [DW-1:0]                     a_div;
  logic [NUM_AXES-1:0][2:0][PW-1:0]  a_por;
  logic [NUM_AXES-1:0][SW-1:0]       a_act;
  logic [NUM_AXES-1:0][CW-1:0]       cnt;
  seg_e                              seg [NUM_AXES];
  logic                              frame_last, load, vs_q, vs_rise;

  assign frame_last = last[0] && last[1];
  assign load       = !a_en || (tick && frame_last);
  assign vs_rise    = sync_raw[1] && !vs_q;

  lcd_tgen_regs #(.PW(PW), .SW(SW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i    (load),
    .vs_rise_i (vs_rise),
    .a_en_o    (a_en),
    .a_dsel_o  (a_dsel),
    .a_inv_o   (a_inv),
    .a_div_o   (a_div),
    .a_por_o   (a_por),
    .a_act_o   (a_act),
    .irq_en_o  (irq_en),
    .pend_o    (irq_pend_o)
  );

  lcd_tgen_pixdiv #(.DW(DW)) u_div (
    .clk_i, .rst_ni,
    .en_i     (a_en),
    .dsel_i   (a_dsel),
    .div_m1_i (a_div),
    .tick_o   (tick)
  );

  for (genvar ax = 0; ax < NUM_AXES; ax++) begin : g_axis
    if (ax == 0) begin : g_h
      assign step[ax] = tick;
    end else begin : g_v
      assign step[ax] = tick && last[0];
    end

    lcd_tgen_axis #(.PW(PW), .SW(SW), .CW(CW)) u_axis (
      .clk_i, .rst_ni,
      .clr_i      (!a_en),
      .step_i     (step[ax]),
      .sync_m1_i  (a_por[ax][0]),
      .back_m1_i  (a_por[ax][1]),
      .act_m1_i   (a_act[ax]),
      .front_m1_i (a_por[ax][2]),
      .seg_o      (seg[ax]),
      .cnt_o      (cnt[ax]),
      .last_o     (last[ax])
    );

    assign sync_raw[ax] = a_en && (seg[ax] == SEG_SYNC);
    assign in_act[ax]   = seg[ax] == SEG_ACT;
    assign sync_out[ax] = sync_raw[ax] ^ a_inv[ax];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vs_q <= 1'b0;
    else         vs_q <= sync_raw[1];
  end

  assign pix_tick_o = tick;
  assign hsync_o    = sync_out[0];
  assign vsync_o    = sync_out[1];
  assign de_o       = a_en && (&in_act);
  assign x_o        = de_o ? cnt[0][SW-1:0] : '0;
  assign y_o        = de_o ? cnt[1][SW-1:0] : '0;
  assign irq_o      = irq_pend_o && irq_en;
endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
  parameter int PW = 8,
  parameter int SW = 11,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [2:0]    wr_addr_i,
  input logic          stat_bit_i,
  input logic          pix_tick_o,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          de_o,
  input logic [SW-1:0] x_o,
  input logic [SW-1:0] y_o,
  input logic          irq_o,
  input logic          irq_pend_o,
  input logic          a_en,
  input logic          a_dsel,
  input logic          a_hinv,
  input logic          a_vinv,
  input logic          frame_last,
  input logic [PW-1:0] a_hsw,
  input logic [SW-1:0] a_hact,
  input logic [DW-1:0] a_div
);
  a_r3_bypass_every_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en && !a_dsel) |-> pix_tick_o);

  a_r7_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_en |-> (!de_o && !pix_tick_o && hsync_o == a_hinv && vsync_o == a_vinv));

  a_r6_coords_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (x_o == '0 && y_o == '0));

  a_r6_de_outside_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_o == a_hinv && vsync_o == a_vinv));

  a_r5_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en && !(pix_tick_o && frame_last)) |=>
      ($stable(a_hsw) && $stable(a_hact) && $stable(a_div) && $stable(a_hinv)));

  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_pend_o);

  a_r8_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_o && !(wr_en_i && wr_addr_i == 3'd4 && stat_bit_i)) |=> irq_pend_o);
endmodule

bind lcd_tgen lcd_tgen_chk #(.PW(PW), .SW(SW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .stat_bit_i (wr_data_i[0]),
  .pix_tick_o (pix_tick_o),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .de_o       (de_o),
  .x_o        (x_o),
  .y_o        (y_o),
  .irq_o      (irq_o),
  .irq_pend_o (irq_pend_o),
  .a_en       (a_en),
  .a_dsel     (a_dsel),
  .a_hinv     (a_inv[0]),
  .a_vinv     (a_inv[1]),
  .frame_last (frame_last),
  .a_hsw      (a_por[0][0]),
  .a_hact     (a_act[0]),
  .a_div      (a_div)
);

// File: tb/lcd_tgen_bench.sv
`timescale 1ns/1ps
module lcd_tgen_bench;
  localparam int SW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          pix_tick, hsync, vsync, de, irq, pend;
  logic [SW-1:0] x, y;

  always #2 clk = ~clk;

  lcd_tgen u_lcd_tgen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pix_tick_o(pix_tick), .hsync_o(hsync),
    .vsync_o(vsync), .de_o(de), .x_o(x), .y_o(y), .irq_o(irq),
    .irq_pend_o(pend)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model: index 0 en,1 dsel,2 hinv,3 vinv,4 div,5 hsw,6 hbp,7 hfp,
  // 8 vsw,9 vbp,10 vfp,11 width,12 height (all minus-one encodings)
  int wk [13];
  int ac [13];
  int m_irqen, m_pend, m_vsq, hp, vp, dc;

  function automatic int htot();
    return ac[5] + ac[6] + ac[11] + ac[7] + 4;
  endfunction
  function automatic int vtot();
    return ac[8] + ac[9] + ac[12] + ac[10] + 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (wk[i]) begin wk[i] = 0; ac[i] = 0; end
      m_irqen = 0; m_pend = 0; m_vsq = 0; hp = 0; vp = 0; dc = 0;
    end else begin
      int tk, lst, ld, vsr;
      tk  = (ac[0] != 0) && (ac[1] == 0 || dc == ac[4]);
      lst = (hp == htot() - 1) && (vp == vtot() - 1);
      ld  = (ac[0] == 0) || (tk && lst);
      vsr = (ac[0] != 0) && (vp <= ac[8]);
      if (vsr && !m_vsq) m_pend = 1;
      else if (wr_en && wr_addr == 3'd4 && wr_data[0]) m_pend = 0;
      if (ac[0] == 0 || ac[1] == 0 || dc == ac[4]) dc = 0; else dc++;
      if (ac[0] == 0) begin
        hp = 0; vp = 0;
      end else if (tk) begin
        if (hp == htot() - 1) begin
          hp = 0;
          vp = (vp == vtot() - 1) ? 0 : vp + 1;
        end else hp++;
      end
      m_vsq = vsr;
      if (ld) ac = wk;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            wk[0] = wr_data[0]; wk[1] = wr_data[1]; wk[2] = wr_data[2];
            wk[3] = wr_data[3]; m_irqen = wr_data[4]; wk[4] = int'(wr_data[15:8]);
          end
          3'd1: begin wk[5] = int'(wr_data[7:0]); wk[6] = int'(wr_data[15:8]); wk[7] = int'(wr_data[23:16]); end
          3'd2: begin wk[8] = int'(wr_data[7:0]); wk[9] = int'(wr_data[15:8]); wk[10] = int'(wr_data[23:16]); end
          3'd3: begin wk[11] = int'(wr_data[SW-1:0]); wk[12] = int'(wr_data[16 +: SW]); end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int en, hx0, vy0, e_de;
      en   = ac[0];
      hx0  = ac[5] + ac[6] + 2;
      vy0  = ac[8] + ac[9] + 2;
      e_de = en && hp >= hx0 && hp <= hx0 + ac[11] && vp >= vy0 && vp <= vy0 + ac[12];
      chk("R3 pix_tick", pix_tick, en && (ac[1] == 0 || dc == ac[4]));
      chk("R4 hsync", hsync, ac[2] ^ (en && hp <= ac[5]));
      chk("R4 vsync", vsync, ac[3] ^ (en && vp <= ac[8]));
      chk("R6 de", de, e_de);
      chk("R6 x", x, e_de ? hp - hx0 : 0);
      chk("R6 y", y, e_de ? vp - vy0 : 0);
      chk("R8 pend", pend, m_pend);
      chk("R8 irq", irq, m_pend && m_irqen);
    end
  end

  function automatic int sig(int sel);
    case (sel)
      0: return int'(hsync);
      1: return int'(vsync);
      2: return int'(de);
      default: return int'(!hsync);
    endcase
  endfunction

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(addr); wr_data = 32'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(input int sel);
    int b;
    b = sig(sel);
    forever begin
      int a;
      @(negedge clk);
      a = sig(sel);
      if (a == 1 && b == 0) break;
      b = a;
    end
  endtask

  task automatic high_len(input int sel, output int n);
    wait_rise(sel);
    n = 1;
    forever begin
      @(negedge clk);
      if (sig(sel) == 0) break;
      n++;
    end
  endtask

  task automatic period(input int sel, output int n);
    int b;
    wait_rise(sel);
    n = 0; b = 1;
    forever begin
      int a;
      @(negedge clk);
      n++;
      a = sig(sel);
      if (a == 1 && b == 0) break;
      b = a;
    end
  endtask

  task automatic de_per_frame(output int n);
    int b;
    wait_rise(1);
    n = 0; b = 1;
    forever begin
      int a;
      if (de) n++;
      @(negedge clk);
      a = sig(1);
      if (a == 1 && b == 0) break;
      b = a;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 hsync", hsync, 0); chk("R1 vsync", vsync, 0); chk("R1 de", de, 0);
    chk("R1 tick", pix_tick, 0); chk("R1 irq", irq, 0); chk("R1 pend", pend, 0);
    chk("R1 x", x, 0); chk("R1 y", y, 0);
    cmp_on = 1;

    // width 4, height 3; h: 2/3/2, v: 1/2/1; divide by 3 (R9 encodings)
    wr(3, (2 << 16) | 3);
    wr(1, 1 | (2 << 8) | (1 << 16));
    wr(2, 0 | (1 << 8) | (0 << 16));
    wr(0, 1 | 2 | 16 | (2 << 8));

    period(1, n);   chk("R2 R3 frame period clocks", n, 11 * 7 * 3);
    high_len(0, n); chk("R4 hsync width clocks", n, 2 * 3);
    de_per_frame(n); chk("R6 de clocks per frame", n, 4 * 3 * 3);
    period(0, n);   chk("R2 line period clocks", n, 11 * 3);

    // R8 pending set and cleared
    wait_rise(1);
    @(negedge clk);
    chk("R8 pend after vsync", pend, 1); chk("R8 irq after vsync", irq, 1);
    wr(4, 1);
    chk("R8 pend cleared", pend, 0);
    // R8 set wins over clear in the same cycle
    wait_rise(1);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'd1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 set beats clear", pend, 1);
    wr(4, 1);

    // R5 mid-frame porch change waits for frame boundary
    wait_rise(2);
    wr(1, 3 | (2 << 8) | (1 << 16));
    high_len(0, n); chk("R5 old hsync width in frame", n, 2 * 3);
    wait_rise(1);
    high_len(0, n); chk("R5 new hsync width next frame", n, 4 * 3);

    // R4 inversion and R3 bypass, applied at the boundary
    wr(0, 1 | 4 | 16);
    wait_rise(1);
    high_len(3, n); chk("R4 R3 inverted hsync low width", n, 4);
    period(1, n);   chk("R2 frame period bypass", n, 13 * 7);

    // R5 R7 stop request mid-frame
    wait_rise(1);
    wait_rise(2);
    wr(0, 4 | 16);
    wait_rise(2);
    chk("R5 de continues after stop write", de, 1);
    repeat (120) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hsync !== 1'b1 || vsync !== 1'b0 || de !== 1'b0 || pix_tick !== 1'b0) bad++;
    end
    chk("R7 idle outputs while stopped", bad, 0);

    // R5 restart while stopped, R2 period
    wr(0, 1);
    period(1, n); chk("R2 R5 restart frame period", n, 13 * 7);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule